// File: doc/BRIEF.md
# Cross-Queue Issue Slot Arbiter

This block decides, every cycle, how many instructions each scheduling queue may send to execution. Three in-order class queues and one out-of-order queue share a single set of functional units. Queue 0 holds instructions whose operands were all ready at dispatch. Queue 1 holds instructions that were nearly ready. Queue 2 holds load-dependent tails. Each class queue reports how many of its head entries it can issue in order, from 0 to 3. The out-of-order queue raises a one-bit request when it has a selected instruction.

A per-cycle mask of free functional units sets the issue budget. The budget is the number of set mask bits, capped at four. The out-of-order queue takes one slot first. The class queues then share what is left, capped at three, and they are served strictly in class order. Each class queue receives a count and pops that many entries from its head.

The grants are pure combinational logic of the current inputs. There is no state, clock or reset. The grant counts are the only handshake: a queue never issues more than it was granted, and any entry it does not issue simply waits at its head for a later cycle.

Top module: `issue_slot_arbiter`

## Requirements
- R1: The sum of all grants (three class-queue counts plus the out-of-order bit) never exceeds 4, and never exceeds the number of set bits in `fu_free_i`.
- R2: `ooo_grant_o` is 1 only when `ooo_req_i` is 1. It is 1 whenever `ooo_req_i` is 1 and at least one bit of `fu_free_i` is set, whatever the class-queue inputs are.
- R3: The three class-queue grants together never exceed 3.
- R4: Each class-queue grant is at most that queue's issuable count. Queue i's count sits at `fifo_avail_i[2i+1:2i]` and its grant at `fifo_grant_o[2i+1:2i]`.
- R5: A lower-priority queue (higher index) gets a non-zero grant only if every higher-priority queue got its full issuable count. Priority order is queue 0, then queue 1, then queue 2.
- R6: The class-queue budget is min(3, min(4, free units) minus the out-of-order grant). Each queue, in priority order, receives min(its count, the budget left over), so no slot is idle while any queue still has issuable entries.
- R7: When `fu_free_i` is all zero, every grant is zero.
- R8: When all inputs are zero, every grant is zero.
- R9: The grants follow a change of inputs within the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fifo_avail_i | input | 6 | Issuable head count for each class queue, 2 bits per queue; queue 0 is in the low bits |
| ooo_req_i | input | 1 | Out-of-order queue has an instruction selected for issue |
| fu_free_i | input | 4 | One bit per free functional unit this cycle |
| fifo_grant_o | output | 6 | Number of entries each class queue may issue, 2 bits per queue, same layout as `fifo_avail_i` |
| ooo_grant_o | output | 1 | Out-of-order queue may issue its instruction |

## Verification
The block holds no state, so a fault shows up at the ports in the same cycle as the inputs that expose it. A budget stage that clamps wrongly shows as a grant total above the free-unit count or above three for the class queues. A wrong subtraction in the priority chain shows as a lower queue being served while a higher queue still has entries, or as a slot left idle. The bench sweeps every combination of mask, request and counts, so any such error is seen on the first input pattern that reaches it.

// File: rtl/iss_arb_pkg.sv
package iss_arb_pkg;
  localparam int unsigned ISS_TOTAL_W  = 4;  // whole-machine issue width
  localparam int unsigned ISS_FIFO_CAP = 3;  // shared in-order budget
  localparam int unsigned ISS_NUM_FIFO = 3;  // class queues
  localparam int unsigned ISS_NUM_FU   = 4;  // functional units in the mask
  localparam int unsigned ISS_CNT_W    = $clog2(ISS_FIFO_CAP + 1);
  localparam int unsigned ISS_BUD_W    = $clog2(ISS_TOTAL_W + 1);
endpackage

// File: rtl/iss_budget.sv
module iss_budget #(
  parameter int unsigned NUM_FU   = 4,
  parameter int unsigned TOTAL_W  = 4,
  parameter int unsigned FIFO_CAP = 3,
  parameter int unsigned BW       = 3
) (
  input  logic [NUM_FU-1:0] fu_free_i,
  input  logic              ooo_req_i,
  output logic              ooo_grant_o,
  output logic [BW-1:0]     fifo_budget_o
);
  localparam int unsigned PW = $clog2(NUM_FU + 1);

  logic [PW-1:0] free_cnt;
  logic [BW-1:0] total_cap;
  logic [BW-1:0] after_ooo;

  always_comb begin
    free_cnt = '0;
    for (int i = 0; i < NUM_FU; i++) free_cnt = free_cnt + PW'(fu_free_i[i]);
  end

  always_comb begin
    if (int'(free_cnt) > int'(TOTAL_W)) total_cap = BW'(TOTAL_W);
    else                                total_cap = BW'(free_cnt);
  end

  // The single out-of-order slot is taken ahead of the class queues.
  assign ooo_grant_o = ooo_req_i && (total_cap != '0);
  assign after_ooo   = total_cap - BW'(ooo_grant_o);

  always_comb begin
    if (int'(after_ooo) > int'(FIFO_CAP)) fifo_budget_o = BW'(FIFO_CAP);
    else                                  fifo_budget_o = after_ooo;
  end

  always_comb begin
    assert_budget_cap_R3: assert (int'(fifo_budget_o) <= int'(FIFO_CAP))
      else $error("class budget above cap");
  end
endmodule

// File: rtl/iss_take.sv
module iss_take #(
  parameter int unsigned CW = 2,
  parameter int unsigned BW = 3
) (
  input  logic [CW-1:0] avail_i,
  input  logic [BW-1:0] left_i,
  output logic [CW-1:0] grant_o,
  output logic [BW-1:0] left_o
);
  always_comb begin
    if (BW'(avail_i) <= left_i) grant_o = avail_i;
    else                        grant_o = CW'(left_i);
    left_o = left_i - BW'(grant_o);
  end
endmodule

// File: rtl/iss_fifo_chain.sv
module iss_fifo_chain #(
  parameter int unsigned NUM_FIFO = 3,
  parameter int unsigned CW       = 2,
  parameter int unsigned BW       = 3
) (
  input  logic [NUM_FIFO*CW-1:0] avail_i,
  input  logic [BW-1:0]          budget_i,
  output logic [NUM_FIFO*CW-1:0] grant_o
);
  logic [BW-1:0] left [NUM_FIFO+1];

  assign left[0] = budget_i;

  for (genvar g = 0; g < NUM_FIFO; g++) begin : g_stage
    iss_take #(.CW(CW), .BW(BW)) take_i (
      .avail_i (avail_i[g*CW +: CW]),
      .left_i  (left[g]),
      .grant_o (grant_o[g*CW +: CW]),
      .left_o  (left[g+1])
    );
  end
endmodule

// File: rtl/issue_slot_arbiter.sv
module issue_slot_arbiter
  import iss_arb_pkg::*;
#(
  parameter int unsigned TOTAL_W  = ISS_TOTAL_W,
  parameter int unsigned FIFO_CAP = ISS_FIFO_CAP,
  parameter int unsigned NUM_FIFO = ISS_NUM_FIFO,
  parameter int unsigned NUM_FU   = ISS_NUM_FU
) (
  input  logic [NUM_FIFO*$clog2(FIFO_CAP+1)-1:0] fifo_avail_i,
  input  logic                                   ooo_req_i,
  input  logic [NUM_FU-1:0]                      fu_free_i,
  output logic [NUM_FIFO*$clog2(FIFO_CAP+1)-1:0] fifo_grant_o,
  output logic                                   ooo_grant_o
);
  localparam int unsigned CW = $clog2(FIFO_CAP + 1);
  localparam int unsigned BW = $clog2(TOTAL_W + 1);

  logic [BW-1:0] fifo_budget;

  iss_budget #(.NUM_FU(NUM_FU), .TOTAL_W(TOTAL_W), .FIFO_CAP(FIFO_CAP), .BW(BW)) budget_i (
    .fu_free_i     (fu_free_i),
    .ooo_req_i     (ooo_req_i),
    .ooo_grant_o   (ooo_grant_o),
    .fifo_budget_o (fifo_budget)
  );

  iss_fifo_chain #(.NUM_FIFO(NUM_FIFO), .CW(CW), .BW(BW)) chain_i (
    .avail_i  (fifo_avail_i),
    .budget_i (fifo_budget),
    .grant_o  (fifo_grant_o)
  );

  // Port-level checks across the budget stage and the priority chain.
  always_comb begin
    int unsigned fsum;
    int unsigned nfree;
    logic        full_above;
    fsum  = 0;
    nfree = 0;
    for (int i = 0; i < NUM_FU; i++) nfree += int'(fu_free_i[i]);
    full_above = 1'b1;
    for (int i = 0; i < NUM_FIFO; i++) begin
      fsum += int'(fifo_grant_o[i*CW +: CW]);
      assert_grant_le_avail_R4: assert (fifo_grant_o[i*CW +: CW] <= fifo_avail_i[i*CW +: CW])
        else $error("grant above issuable count");
      assert_class_priority_R5: assert (full_above || fifo_grant_o[i*CW +: CW] == '0)
        else $error("lower class served before higher");
      full_above = full_above && (fifo_grant_o[i*CW +: CW] == fifo_avail_i[i*CW +: CW]);
    end
    assert_fifo_sum_R3: assert (fsum <= FIFO_CAP)
      else $error("class queues over budget");
    assert_total_issue_R1: assert ((fsum + int'(ooo_grant_o) <= TOTAL_W) &&
                                   (fsum + int'(ooo_grant_o) <= nfree))
      else $error("total issue over budget");
    assert_ooo_rule_R2: assert (ooo_grant_o == (ooo_req_i && (nfree != 0)))
      else $error("out-of-order grant wrong");
  end
endmodule

// File: tb/issue_slot_arbiter_tb.sv
module issue_slot_arbiter_tb_top;
  logic       clk = 1'b0;
  logic [5:0] avail;
  logic       req;
  logic [3:0] mask;
  logic [5:0] grant;
  logic       ogrant;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  issue_slot_arbiter dut_i (
    .fifo_avail_i (avail),
    .ooo_req_i    (req),
    .fu_free_i    (mask),
    .fifo_grant_o (grant),
    .ooo_grant_o  (ogrant)
  );

  // {mask[4], req, a0, a1, a2, g0, g1, g2, ooo}
  localparam logic [17:0] VEC [13] = '{
    {4'hF,1'b1,2'd3,2'd3,2'd3, 2'd3,2'd0,2'd0,1'b1},
    {4'hF,1'b0,2'd1,2'd1,2'd1, 2'd1,2'd1,2'd1,1'b0},
    {4'hF,1'b1,2'd0,2'd2,2'd3, 2'd0,2'd2,2'd1,1'b1},
    {4'hF,1'b0,2'd0,2'd0,2'd3, 2'd0,2'd0,2'd3,1'b0},
    {4'h3,1'b1,2'd3,2'd0,2'd0, 2'd1,2'd0,2'd0,1'b1},
    {4'h0,1'b1,2'd3,2'd3,2'd3, 2'd0,2'd0,2'd0,1'b0},
    {4'h1,1'b1,2'd2,2'd2,2'd2, 2'd0,2'd0,2'd0,1'b1},
    {4'h1,1'b0,2'd1,2'd2,2'd0, 2'd1,2'd0,2'd0,1'b0},
    {4'h7,1'b0,2'd2,2'd2,2'd2, 2'd2,2'd1,2'd0,1'b0},
    {4'hF,1'b1,2'd0,2'd0,2'd0, 2'd0,2'd0,2'd0,1'b1},
    {4'h5,1'b0,2'd0,2'd1,2'd3, 2'd0,2'd1,2'd1,1'b0},
    {4'hF,1'b0,2'd2,2'd0,2'd3, 2'd2,2'd0,2'd1,1'b0},
    {4'hA,1'b1,2'd0,2'd0,2'd2, 2'd0,2'd0,2'd1,1'b1}
  };

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] model(input logic [3:0] m, input logic r, input logic [5:0] a);
    int tot, bud, g[3];
    logic o;
    tot = $countones(m);
    if (tot > 4) tot = 4;
    o = r && (tot > 0);
    bud = tot - int'(o);
    if (bud > 3) bud = 3;
    for (int i = 0; i < 3; i++) begin
      g[i] = (int'(a[i*2 +: 2]) < bud) ? int'(a[i*2 +: 2]) : bud;
      bud -= g[i];
    end
    return {2'(g[0]), 2'(g[1]), 2'(g[2]), o};
  endfunction

  function automatic logic [6:0] outs();
    return {grant[1:0], grant[3:2], grant[5:4], ogrant};
  endfunction

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    avail = '0; req = 1'b0; mask = '0;
    @(negedge clk); #1;
    check("R8 idle inputs", outs(), 7'b0);

    // Table of vectors
    for (int v = 0; v < 13; v++) begin
      @(negedge clk);
      mask  = VEC[v][17:14];
      req   = VEC[v][13];
      avail = {VEC[v][8:7], VEC[v][10:9], VEC[v][12:11]};
      #1;
      check($sformatf("R1 R2 R3 R5 R6 vector %0d", v), outs(), VEC[v][6:0]);
    end

    // R7: no free unit blocks everything
    @(negedge clk);
    mask = 4'h0; req = 1'b1; avail = 6'b111111; #1;
    check("R7 no free units", outs(), 7'b0);

    // R9: same-cycle response to input change, no clock edge between
    @(negedge clk);
    mask = 4'hF; req = 1'b0; avail = 6'b000011; #1;
    check("R9 before change", outs(), {2'd3, 2'd0, 2'd0, 1'b0});
    avail = 6'b110000; #1;
    check("R9 after change", outs(), {2'd0, 2'd0, 2'd3, 1'b0});

    // R2: out-of-order slot independent of class inputs
    @(negedge clk);
    mask = 4'h8; req = 1'b1; avail = 6'b111111; #1;
    check("R2 ooo with one unit", outs(), {2'd0, 2'd0, 2'd0, 1'b1});

    // R4: grant never exceeds count when budget is ample
    @(negedge clk);
    mask = 4'hF; req = 1'b1; avail = 6'b000001; #1;
    check("R4 count limits grant", outs(), {2'd1, 2'd0, 2'd0, 1'b1});

    // Full sweep against the requirement model (R1 R3 R4 R5 R6)
    for (int m = 0; m < 16; m++)
      for (int r = 0; r < 2; r++)
        for (int a = 0; a < 64; a++) begin
          mask = 4'(m); req = 1'(r); avail = 6'(a);
          #1;
          check($sformatf("R6 sweep m=%0d r=%0d a=%0d", m, r, a),
                outs(), model(4'(m), 1'(r), 6'(a)));
        end

    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule